// File: doc/BRIEF.md
# Retriggerable One-Shot Pulse Generator

This block turns input transitions into a clock-timed output pulse. Each channel has two trigger inputs, and each trigger input is gated by the level of the other. `trig_fall_i` starts a pulse on its high-to-low transition, but only while `trig_rise_i` is high. `trig_rise_i` starts a pulse on its low-to-high transition, but only while `trig_fall_i` is low. The pulse lasts a run-time number of clock cycles, and a qualifying trigger that arrives during a pulse starts the full count again from that point. A per-channel clear input, active low, overrides every trigger and ends any pulse in progress. Each channel drives a true output and a complementary output.

All three inputs of a channel are asynchronous. Each passes through a two-flop synchronizer, and triggers are evaluated only on synchronized transitions. A per-channel mask parameter selects whether the release of the clear input also counts as a trigger. Channels are fully independent: each has its own pins, its own counter and its own outputs.

Top module: `oneshot_bank`

## Requirements
- R1: While `rst_n` is low, every `pulse_o` bit is 0 and every `pulse_n_o` bit is 1. After `rst_n` is released, no pulse is started from the input levels present at release. Only transitions seen after release count.
- R2: If `trig_fall_i` goes from 1 to 0 while `trig_rise_i` is 1 and `clr_n_i` is 1, `pulse_o` rises on the third rising clock edge after the input change. It stays high for exactly N cycles, where N is the channel's field of `width_i`.
- R3: If `trig_rise_i` goes from 0 to 1 while `trig_fall_i` is 0 and `clr_n_i` is 1, a pulse of N cycles is started with the same latency as R2.
- R4: While `trig_fall_i` is held at 1, or while `trig_rise_i` is held at 0, activity on the other trigger input starts no pulse, and `pulse_o` stays 0.
- R5: While `clr_n_i` is low, `pulse_o` is 0 from the third clock edge after the fall of `clr_n_i`, so a pulse in progress is cut short. Trigger transitions seen while the clear is low are discarded.
- R6: In a channel whose bit of `CLR_TRIG_MASK` is 1, a 0-to-1 transition of `clr_n_i` while `trig_fall_i` is 0 and `trig_rise_i` is 1 starts a pulse of N cycles. In a channel whose bit is 0, the release of the clear never starts a pulse.
- R7: A qualifying trigger during a pulse that arrives at least `MIN_GAP` cycles after the last accepted trigger reloads the full count. The pulse then ends N cycles after the retrigger.
- R8: A qualifying trigger during a pulse that arrives fewer than `MIN_GAP` cycles after the last accepted trigger is ignored. The pulse ends N cycles after the earlier trigger.
- R9: A width field of 0 is treated as 1, giving a one-cycle pulse.
- R10: `pulse_n_o` is the bitwise complement of `pulse_o` in every cycle.
- R11: A trigger on one channel leaves the output of every other channel unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous global reset, active low |
| trig_fall_i | input | NUM_CH | Falling-edge trigger, one bit per channel |
| trig_rise_i | input | NUM_CH | Rising-edge trigger, one bit per channel |
| clr_n_i | input | NUM_CH | Overriding clear, active low, one bit per channel |
| width_i | input | NUM_CH*CNT_W | Pulse width in cycles; channel k uses bits [k*CNT_W +: CNT_W] |
| pulse_o | output | NUM_CH | True pulse output |
| pulse_n_o | output | NUM_CH | Complementary pulse output |

## Verification
The bench builds the block with two channels and `MIN_GAP` of 4. `CLR_TRIG_MASK` is 2'b01, so one channel has clear-release triggering and the other does not, and a single clear sequence shows both modes side by side. With a width of 10 cycles, retriggers spaced 3, 4 and 5 cycles apart all fall inside a live pulse. The accept/ignore boundary of the minimum retrigger interval therefore shows up directly as the total number of high cycles.

// File: rtl/oneshot_pkg.sv
// Shared types for the one-shot pulse generator.
// Assumes: nothing beyond a single clock domain after synchronization.
package oneshot_pkg;

    // Synchronized view of one channel's input pins.
    typedef struct packed {
        logic fall_pin;   // falling-edge trigger level
        logic rise_pin;   // rising-edge trigger level
        logic clr_lvl;    // clear level, 1 = not cleared
    } os_pins_t;

endpackage

// File: rtl/os_sync.sv
// Two-flop synchronizer for a bundle of asynchronous inputs.
// Assumes: every bit is an independent level; no bus coherency is needed.
module os_sync #(
    parameter int WIDTH = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] stage1;

    // Two register stages to resolve metastability.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            sync_o <= '0;
        end else begin
            stage1 <= async_i;
            sync_o <= stage1;
        end
    end

endmodule

// File: rtl/os_trigger.sv
// Edge detection and gating for one channel.
// Produces a one-cycle fire strobe when a qualifying transition is seen.
// Assumes: the inputs are already synchronized. Edges are suppressed until
// the synchronizer and history registers hold real post-reset samples.
module os_trigger
    import oneshot_pkg::*;
#(
    parameter bit CLR_TRIG = 1'b1
) (
    input  logic     clk,
    input  logic     rst_n,
    input  os_pins_t pins_i,
    output logic     fire_o
);

    localparam int PRIME_LEN = 3;

    os_pins_t               prev;
    logic [PRIME_LEN-1:0]   prime;
    logic                   fall_hit;
    logic                   rise_hit;
    logic                   clr_hit;

    // Hold the previous synchronized sample and track history validity.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev  <= '0;
            prime <= '0;
        end else begin
            prev  <= pins_i;
            prime <= {prime[PRIME_LEN-2:0], 1'b1};
        end
    end

    // Gated trigger conditions on synchronized transitions.
    always_comb begin
        fall_hit = prev.fall_pin && !pins_i.fall_pin && pins_i.rise_pin && pins_i.clr_lvl;
        rise_hit = !prev.rise_pin && pins_i.rise_pin && !pins_i.fall_pin && pins_i.clr_lvl;
        clr_hit  = CLR_TRIG && !prev.clr_lvl && pins_i.clr_lvl
                   && !pins_i.fall_pin && pins_i.rise_pin;
        fire_o   = prime[PRIME_LEN-1] && (fall_hit || rise_hit || clr_hit);
    end

endmodule

// File: rtl/os_timer.sv
// Pulse counter for one channel: starts and retriggers the pulse,
// applies the minimum retrigger interval and the clear override.
// Assumes: fire_i is a single-cycle strobe; clr_lvl_i is synchronized.
module os_timer #(
    parameter int CNT_W   = 8,
    parameter int MIN_GAP = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fire_i,
    input  logic             clr_lvl_i,
    input  logic [CNT_W-1:0] width_i,
    output logic             pulse_o,
    output logic             pulse_n_o
);

    localparam int               GAP_W   = $clog2(MIN_GAP + 1);
    localparam logic [GAP_W-1:0] GAP_MAX = GAP_W'(MIN_GAP);
    localparam logic [GAP_W-1:0] GAP_LIM = GAP_W'(MIN_GAP - 1);

    logic [CNT_W-1:0] remain;
    logic [GAP_W-1:0] since;
    logic [CNT_W-1:0] load_val;
    logic             accept;

    // Width of 0 becomes 1; retriggers need the gap to be reached.
    always_comb begin
        load_val = (width_i == '0) ? CNT_W'(1) : width_i;
        accept   = fire_i && (!pulse_o || since >= GAP_LIM);
    end

    // Pulse state: clear first, then accepted trigger, then countdown.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse_o   <= 1'b0;
            pulse_n_o <= 1'b1;
            remain    <= '0;
            since     <= GAP_MAX;
        end else if (!clr_lvl_i) begin
            pulse_o   <= 1'b0;
            pulse_n_o <= 1'b1;
            remain    <= '0;
            since     <= GAP_MAX;
        end else if (accept) begin
            pulse_o   <= 1'b1;
            pulse_n_o <= 1'b0;
            remain    <= load_val;
            since     <= '0;
        end else begin
            if (since != GAP_MAX) since <= since + 1'b1;
            if (pulse_o) begin
                if (remain <= CNT_W'(1)) begin
                    pulse_o   <= 1'b0;
                    pulse_n_o <= 1'b1;
                    remain    <= '0;
                end else begin
                    remain <= remain - 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/oneshot_bank.sv
// Bank of independent retriggerable one-shot channels.
// Each channel synchronizes its pins, detects gated trigger transitions
// and runs its own pulse counter.
// Assumes: all pins are asynchronous; width_i is quasi-static.
module oneshot_bank
    import oneshot_pkg::*;
#(
    parameter int              NUM_CH        = 2,
    parameter int              CNT_W         = 8,
    parameter int              MIN_GAP       = 4,
    parameter logic [NUM_CH-1:0] CLR_TRIG_MASK = 2'b01
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_CH-1:0]       trig_fall_i,
    input  logic [NUM_CH-1:0]       trig_rise_i,
    input  logic [NUM_CH-1:0]       clr_n_i,
    input  logic [NUM_CH*CNT_W-1:0] width_i,
    output logic [NUM_CH-1:0]       pulse_o,
    output logic [NUM_CH-1:0]       pulse_n_o
);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        os_pins_t pins_raw;
        os_pins_t pins_sync;
        logic     fire;

        // Bundle this channel's pins for the synchronizer.
        always_comb begin
            pins_raw.fall_pin = trig_fall_i[g];
            pins_raw.rise_pin = trig_rise_i[g];
            pins_raw.clr_lvl  = clr_n_i[g];
        end

        os_sync #(.WIDTH($bits(os_pins_t))) u_sync (
            .clk     (clk),
            .rst_n   (rst_n),
            .async_i (pins_raw),
            .sync_o  (pins_sync)
        );

        os_trigger #(.CLR_TRIG(CLR_TRIG_MASK[g])) u_trig (
            .clk    (clk),
            .rst_n  (rst_n),
            .pins_i (pins_sync),
            .fire_o (fire)
        );

        os_timer #(.CNT_W(CNT_W), .MIN_GAP(MIN_GAP)) u_timer (
            .clk       (clk),
            .rst_n     (rst_n),
            .fire_i    (fire),
            .clr_lvl_i (pins_sync.clr_lvl),
            .width_i   (width_i[g*CNT_W +: CNT_W]),
            .pulse_o   (pulse_o[g]),
            .pulse_n_o (pulse_n_o[g])
        );
    end

endmodule

// File: rtl/oneshot_bank_chk.sv
// Port-level property checker for oneshot_bank, attached by bind.
// Assumes: input pins are sampled on the same clock as the design.
module oneshot_bank_chk #(
    parameter int NUM_CH = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_CH-1:0] trig_fall_i,
    input logic [NUM_CH-1:0] trig_rise_i,
    input logic [NUM_CH-1:0] clr_n_i,
    input logic [NUM_CH-1:0] pulse_o,
    input logic [NUM_CH-1:0] pulse_n_o
);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
        // R1: reset drives the idle output state.
        p_reset_idle_r1: assert property (@(posedge clk)
            !rst_n |=> (!pulse_o[g] && pulse_n_o[g]));

        // R10: the two outputs are always complementary.
        p_complement_r10: assert property (@(posedge clk) disable iff (!rst_n)
            pulse_n_o[g] == !pulse_o[g]);

        // R5: a clear held low for four samples keeps the output low.
        p_clear_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (!clr_n_i[g] && !$past(clr_n_i[g]) && !$past(clr_n_i[g], 2)
             && !$past(clr_n_i[g], 3)) |-> !pulse_o[g]);

        // R4: a blocking level on either trigger pin prevents a new pulse.
        p_blocked_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (!pulse_o[g] &&
             (($past(trig_fall_i[g], 2) && $past(trig_fall_i[g], 3)) ||
              (!$past(trig_rise_i[g], 2) && !$past(trig_rise_i[g], 3))))
            |=> !pulse_o[g]);
    end

endmodule

bind oneshot_bank oneshot_bank_chk #(.NUM_CH(NUM_CH)) u_oneshot_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .trig_fall_i (trig_fall_i),
    .trig_rise_i (trig_rise_i),
    .clr_n_i     (clr_n_i),
    .pulse_o     (pulse_o),
    .pulse_n_o   (pulse_n_o)
);

// File: tb/tb_oneshot_bank.sv
// Directed bench for oneshot_bank: one task per scenario.
module tb_oneshot_bank;

    localparam int NUM_CH = 2;
    localparam int CNT_W  = 8;
    localparam int N      = 10;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic [NUM_CH-1:0]       trig_fall_i;
    logic [NUM_CH-1:0]       trig_rise_i;
    logic [NUM_CH-1:0]       clr_n_i;
    logic [NUM_CH*CNT_W-1:0] width_i;
    logic [NUM_CH-1:0]       pulse_o;
    logic [NUM_CH-1:0]       pulse_n_o;

    int n_checks = 0;
    int n_fail   = 0;
    int comp_err = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    oneshot_bank #(
        .NUM_CH(NUM_CH), .CNT_W(CNT_W), .MIN_GAP(4), .CLR_TRIG_MASK(2'b01)
    ) dut (
        .clk(clk), .rst_n(rst_n), .trig_fall_i(trig_fall_i),
        .trig_rise_i(trig_rise_i), .clr_n_i(clr_n_i), .width_i(width_i),
        .pulse_o(pulse_o), .pulse_n_o(pulse_n_o)
    );

    task automatic check(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Count high cycles on each channel over len negedges; track complement.
    task automatic observe(int len, output int h0, output int h1);
        h0 = 0;
        h1 = 0;
        for (int c = 0; c < len; c++) begin
            @(negedge clk);
            if (pulse_o[0]) h0++;
            if (pulse_o[1]) h1++;
            if (pulse_n_o != ~pulse_o) comp_err++;
        end
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic go_idle();
        @(negedge clk);
        trig_rise_i = '0;
        @(negedge clk);
        trig_fall_i = '1;
        clr_n_i     = '1;
        idle(20);
    endtask

    task automatic t_reset();
        int h0, h1;
        trig_fall_i = '0;
        trig_rise_i = '1;
        clr_n_i     = '1;
        width_i     = {CNT_W'(N), CNT_W'(N)};
        rst_n       = 1'b0;
        idle(4);
        check("R1 reset pulse_o", int'(pulse_o), 0);
        check("R1 reset pulse_n_o", int'(pulse_n_o), 3);
        rst_n = 1'b1;
        observe(25, h0, h1);
        check("R1 no pulse from levels at release", h0 + h1, 0);
        go_idle();
    endtask

    task automatic t_fall_trigger();
        int h0, h1;
        @(negedge clk); trig_rise_i[0] = 1'b1;
        idle(6);
        fork
            begin @(negedge clk); trig_fall_i[0] = 1'b0; end
            observe(30, h0, h1);
        join
        check("R2 fall trigger width", h0, N);
        check("R11 other channel quiet", h1, 0);
        go_idle();
    endtask

    task automatic t_fall_latency();
        @(negedge clk); trig_rise_i[0] = 1'b1;
        idle(6);
        @(negedge clk); trig_fall_i[0] = 1'b0;
        @(negedge clk); @(negedge clk);
        check("R2 not yet high after two edges", int'(pulse_o[0]), 0);
        @(negedge clk);
        check("R2 high after third edge", int'(pulse_o[0]), 1);
        idle(20);
        go_idle();
    endtask

    task automatic t_rise_trigger();
        int h0, h1;
        @(negedge clk); trig_fall_i[1] = 1'b0;
        idle(6);
        fork
            begin @(negedge clk); trig_rise_i[1] = 1'b1; end
            observe(30, h0, h1);
        join
        check("R3 rise trigger width", h1, N);
        check("R11 other channel quiet", h0, 0);
        go_idle();
    endtask

    task automatic t_blocked();
        int h0, h1;
        // A held high: rising edges on the other pin do nothing.
        fork
            begin
                for (int k = 0; k < 3; k++) begin
                    @(negedge clk); trig_rise_i[0] = 1'b1;
                    idle(4);
                    @(negedge clk); trig_rise_i[0] = 1'b0;
                    idle(4);
                end
            end
            observe(40, h0, h1);
        join
        check("R4 fall pin high blocks", h0, 0);
        // B held low: falling edges on the other pin do nothing.
        fork
            begin
                for (int k = 0; k < 3; k++) begin
                    @(negedge clk); trig_fall_i[0] = 1'b0;
                    idle(4);
                    @(negedge clk); trig_fall_i[0] = 1'b1;
                    idle(4);
                end
            end
            observe(40, h0, h1);
        join
        check("R4 rise pin low blocks", h0, 0);
        go_idle();
    endtask

    task automatic t_clear();
        int h0, h1;
        @(negedge clk); trig_fall_i = '0;
        idle(6);
        fork
            begin
                @(negedge clk); trig_rise_i = '1;
                idle(4);
                @(negedge clk); clr_n_i = '0;
                idle(4);
                @(negedge clk); trig_rise_i = '0;
                idle(2);
                @(negedge clk); trig_rise_i = '1;
                idle(8);
                @(negedge clk); clr_n_i = '1;
            end
            observe(60, h0, h1);
        join
        check("R5 clear cuts pulse, triggers discarded", h1, 5);
        check("R6 clear release triggers in enabled channel", h0, 5 + N);
        go_idle();
    endtask

    task automatic t_retrig(int gap, int expect_hi, string req);
        int h0, h1;
        @(negedge clk); trig_fall_i[1] = 1'b0;
        idle(6);
        fork
            begin
                @(negedge clk); trig_rise_i[1] = 1'b1;
                @(negedge clk); trig_rise_i[1] = 1'b0;
                idle(gap - 2);
                @(negedge clk); trig_rise_i[1] = 1'b1;
                @(negedge clk); trig_rise_i[1] = 1'b0;
            end
            observe(45, h0, h1);
        join
        check(req, h1, expect_hi);
        go_idle();
    endtask

    task automatic t_zero_width();
        int h0, h1;
        width_i[0 +: CNT_W] = '0;
        @(negedge clk); trig_fall_i[0] = 1'b0;
        idle(6);
        fork
            begin @(negedge clk); trig_rise_i[0] = 1'b1; end
            observe(20, h0, h1);
        join
        check("R9 zero width gives one cycle", h0, 1);
        width_i[0 +: CNT_W] = CNT_W'(N);
        go_idle();
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        t_reset();
        t_fall_trigger();
        t_fall_latency();
        t_rise_trigger();
        t_blocked();
        t_clear();
        t_retrig(5, N + 5, "R7 retrigger at gap 5 extends");
        t_retrig(4, N + 4, "R7 retrigger at gap 4 extends");
        t_retrig(3, N, "R8 retrigger at gap 3 ignored");
        t_retrig(2, N, "R8 retrigger at gap 2 ignored");
        t_zero_width();
        check("R10 complement mismatches", comp_err, 0);
        finished = 1'b1;
        report();
    end

    initial begin
        #(200000 * 10);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
        end
    end

endmodule